// File: doc/BRIEF.md
# Dual-Rail Ripple-Carry Adder

This block adds two N-bit operands that arrive in dual-rail form and returns an (N+1)-bit dual-rail sum. The top bit of the sum is the final carry. In dual-rail form, a bit holding 1 has its true rail high and its false rail low. A bit holding 0 has its false rail high and its true rail low. A neutral bit has both rails low. The environment drives a fully valid operand pair and waits for the completion flag. It then returns both operands to neutral and waits for the idle flag before it presents the next pair.

The model works in cycles. Every output rail is a register. On each clock edge a rail evaluates its set guard and its clear guard once, so one cycle stands in for one gate delay. The N cells are identical, and each cell feeds its carry-out straight into the carry-in of the cell above it. A cell's carry goes valid as soon as its two operand bits agree, without waiting for its carry-in. The time to completion therefore follows the longest chain of positions where the operand bits differ, not the width N.

Top module: `dr_ripple_adder`

## Requirements
- R1: Encoding: 1 is (t=1,f=0), 0 is (t=0,f=1), neutral is (0,0). Bit i of a vector port is position i. With both operands valid, the decoded sum, including bit N, equals A+B with a carry into position 0 of zero.
- R2: Each output rail is a register. Reset clears it. It is set in the cycle after its set guard is true, cleared in the cycle after its clear guard is true, and otherwise keeps its value.
- R3: The sum true rail of cell k is set by (cin_t & eq) | (cin_f & dif). The false rail is set by (cin_f & eq) | (cin_t & dif). Here eq = at&bt | af&bf and dif = at&bf | af&bt. Both sum rails clear when both carry-in rails are low.
- R4: The carry true rail is set by at&bt | (at|bt)&cin_t. The false rail is set by af&bf | (af|bf)&cin_f. Equal operand bits therefore give a valid carry one cycle after the operands arrive. Both carry rails clear one cycle after all four operand rails are low.
- R5: The carry into cell 0 is a constant 0. Its false rail is set one cycle after bit 0 of A is valid and cleared one cycle after it is neutral. Its true rail never rises. As a result, no sum bit below N is valid one cycle after the operands are applied.
- R6: Latency follows a recurrence. The carry into position 0 is valid at cycle 1. A carry-out is valid at cycle 1 if the bits at that position are equal, and otherwise one cycle after its carry-in. A sum bit is valid one cycle after its carry-in. done_o first rises at the latest of these times. When all bits differ, that time is N+1.
- R7: done_o is high exactly when all N+1 sum bits are valid. idle_o is high exactly when every sum rail is low. Both flags are combinational from the rails and are never high together.
- R8: Once both operands are fully neutral, idle_o is high two cycles later, and done_o is low one cycle later.
- R9: No sum bit ever has both rails high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one edge stands for one gate delay |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_t_i | input | N | Operand A, true rails |
| a_f_i | input | N | Operand A, false rails |
| b_t_i | input | N | Operand B, true rails |
| b_f_i | input | N | Operand B, false rails |
| sum_t_o | output | N+1 | Sum true rails; bit N is the final carry |
| sum_f_o | output | N+1 | Sum false rails |
| done_o | output | 1 | All sum bits valid |
| idle_o | output | 1 | All sum rails low |

## Verification
The bench drives operands at the falling edge and counts falling edges until done_o is seen high. That count is compared with the latency from the R6 recurrence, which the bench evaluates independently for each operand pair. One edge after the operands are applied, only the top carry may be valid, and only if the top operand bits agree. After neutral operands are applied, done_o must be low one edge later and idle_o high two edges later. Outputs are sampled at the falling edge, so every value read was registered at the rising edge just before. Random operand pairs are mixed with pairs that are all equal, all differing, alternating, and zero.

// File: rtl/dr_add_pkg.sv
package dr_add_pkg;
  localparam int NUM_RAILS = 4;
  localparam int RAIL_ST   = 0;
  localparam int RAIL_SF   = 1;
  localparam int RAIL_CT   = 2;
  localparam int RAIL_CF   = 3;

  function automatic logic dr_eq(logic at, logic af, logic bt, logic bf);
    return (at & bt) | (af & bf);
  endfunction

  function automatic logic dr_dif(logic at, logic af, logic bt, logic bf);
    return (at & bf) | (af & bt);
  endfunction
endpackage

// File: rtl/dr_add_rail.sv
module dr_add_rail (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R2
  rail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/dr_add_cin.sv
module dr_add_cin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a0_t_i,
  input  logic a0_f_i,
  output logic c_t_o,
  output logic c_f_o
);
  logic a0_valid;
  assign a0_valid = a0_t_i | a0_f_i;
  assign c_t_o    = 1'b0;

  dr_add_rail u_cf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (a0_valid),
    .clr_i (~a0_valid),
    .q_o   (c_f_o)
  );

  // R5
  cin_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a0_valid |=> c_f_o);
  // R5
  cin_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a0_valid |=> !c_f_o);
endmodule

// File: rtl/dr_add_cell.sv
module dr_add_cell
  import dr_add_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_t_i,
  input  logic a_f_i,
  input  logic b_t_i,
  input  logic b_f_i,
  input  logic ci_t_i,
  input  logic ci_f_i,
  output logic s_t_o,
  output logic s_f_o,
  output logic co_t_o,
  output logic co_f_o
);
  logic eq, dif, ab_neutral, ci_neutral;
  logic [NUM_RAILS-1:0] set_v, clr_v, q_v;

  always_comb begin
    eq         = dr_eq(a_t_i, a_f_i, b_t_i, b_f_i);
    dif        = dr_dif(a_t_i, a_f_i, b_t_i, b_f_i);
    ab_neutral = ~(a_t_i | a_f_i | b_t_i | b_f_i);
    ci_neutral = ~(ci_t_i | ci_f_i);
    set_v[RAIL_ST] = (ci_t_i & eq) | (ci_f_i & dif);
    set_v[RAIL_SF] = (ci_f_i & eq) | (ci_t_i & dif);
    set_v[RAIL_CT] = (a_t_i & b_t_i) | ((a_t_i | b_t_i) & ci_t_i);
    set_v[RAIL_CF] = (a_f_i & b_f_i) | ((a_f_i | b_f_i) & ci_f_i);
    clr_v[RAIL_ST] = ci_neutral;
    clr_v[RAIL_SF] = ci_neutral;
    clr_v[RAIL_CT] = ab_neutral;
    clr_v[RAIL_CF] = ab_neutral;
  end

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    dr_add_rail u_rail (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (q_v[g])
    );
  end

  assign s_t_o  = q_v[RAIL_ST];
  assign s_f_o  = q_v[RAIL_SF];
  assign co_t_o = q_v[RAIL_CT];
  assign co_f_o = q_v[RAIL_CF];

  // R9
  sum_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_t_o && s_f_o));
  // R3
  sum_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(s_t_o) || $rose(s_f_o)) |-> $past(ci_t_i | ci_f_i));
  // R4
  carry_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq |=> (co_t_o | co_f_o));
  // R4
  carry_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_neutral |=> !(co_t_o | co_f_o));
endmodule

// File: rtl/dr_add_done.sv
module dr_add_done #(
  parameter int W = 9
) (
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] f_i,
  output logic         done_o,
  output logic         idle_o
);
  assign done_o = &(t_i ^ f_i);
  assign idle_o = ~|(t_i | f_i);
endmodule

// File: rtl/dr_ripple_adder.sv
module dr_ripple_adder #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] a_t_i,
  input  logic [N-1:0] a_f_i,
  input  logic [N-1:0] b_t_i,
  input  logic [N-1:0] b_f_i,
  output logic [N:0]   sum_t_o,
  output logic [N:0]   sum_f_o,
  output logic         done_o,
  output logic         idle_o
);
  localparam int SW = N + 1;

  logic [N:0] c_t, c_f;

  dr_add_cin u_cin (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a0_t_i(a_t_i[0]),
    .a0_f_i(a_f_i[0]),
    .c_t_o (c_t[0]),
    .c_f_o (c_f[0])
  );

  for (genvar k = 0; k < N; k++) begin : g_cell
    dr_add_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_t_i (a_t_i[k]),
      .a_f_i (a_f_i[k]),
      .b_t_i (b_t_i[k]),
      .b_f_i (b_f_i[k]),
      .ci_t_i(c_t[k]),
      .ci_f_i(c_f[k]),
      .s_t_o (sum_t_o[k]),
      .s_f_o (sum_f_o[k]),
      .co_t_o(c_t[k+1]),
      .co_f_o(c_f[k+1])
    );
  end

  assign sum_t_o[N] = c_t[N];
  assign sum_f_o[N] = c_f[N];

  dr_add_done #(.W(SW)) u_done (
    .t_i   (sum_t_o),
    .f_i   (sum_f_o),
    .done_o(done_o),
    .idle_o(idle_o)
  );

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && idle_o));
  // R8
  idle_reach_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~|{a_t_i, a_f_i, b_t_i, b_f_i} && $past(~|{a_t_i, a_f_i, b_t_i, b_f_i}))
    |=> idle_o);
  // R5
  cin_true_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_t[0]);
endmodule

// File: tb/dr_ripple_adder_tb_top.sv
`timescale 1ns/1ps
module dr_ripple_adder_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] a_t, a_f, b_t, b_f;
  logic [N:0] s_t, s_f;
  logic done, idle;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dr_ripple_adder #(.N(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_t_i(a_t), .a_f_i(a_f), .b_t_i(b_t), .b_f_i(b_f),
    .sum_t_o(s_t), .sum_f_o(s_f), .done_o(done), .idle_o(idle)
  );

  function automatic int exp_lat(logic [N-1:0] a, logic [N-1:0] b);
    int c = 1;
    int m = 0;
    for (int k = 0; k < N; k++) begin
      if (c + 1 > m) m = c + 1;
      c = (a[k] == b[k]) ? 1 : c + 1;
    end
    if (c > m) m = c;
    return m;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(logic [N-1:0] a, logic [N-1:0] b);
    int n = 0;
    bit both = 0;
    logic [N:0] hold_t;
    a_t = a; a_f = ~a; b_t = b; b_f = ~b;
    @(negedge clk); n = 1;
    // R4 R5: after one cycle only the top carry can be valid
    chk((s_t[N-1:0] | s_f[N-1:0]) == '0, "R5", longint'(s_t | s_f), 0);
    chk((s_t[N] | s_f[N]) == (a[N-1] == b[N-1]), "R4",
        longint'(s_t[N] | s_f[N]), longint'(a[N-1] == b[N-1]));
    while (!done && n < 100) begin
      if ((s_t & s_f) != '0) both = 1;
      @(negedge clk); n++;
    end
    chk(!both, "R9", longint'(both), 0);
    chk(n == exp_lat(a, b), "R6", n, exp_lat(a, b));
    chk(s_t == ({1'b0, a} + {1'b0, b}) && s_f == ~s_t, "R1",
        longint'(s_t), longint'({1'b0, a} + {1'b0, b}));
    hold_t = s_t;
    repeat (2) @(negedge clk);
    // R2 R3: rails hold while operands stay valid
    chk(s_t == hold_t && done, "R2", longint'(s_t), longint'(hold_t));
    a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    @(negedge clk);
    chk(!done, "R8", longint'(done), 0);
    @(negedge clk);
    chk(idle && s_t == '0 && s_f == '0, "R8", longint'(idle), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    repeat (3) @(negedge clk);
    // R2 R7: reset state
    chk(idle && !done && s_t == '0 && s_f == '0, "R7", longint'(idle), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    apply('0, '0);
    apply('1, '1);
    apply('1, '0);
    chk(exp_lat('1, '0) == N + 1, "R6", exp_lat('1, '0), N + 1);
    apply(8'h55, 8'hAA);
    apply(8'h0F, 8'h01);
    apply(8'h80, 8'h80);
    apply(8'h3C, 8'hC3);
    for (int i = 0; i < 60; i++) apply(N'($urandom), N'($urandom));
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule